// File: doc/BRIEF.md
# Banked Level-Sensitive Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt lines, organised in banks of 32 (three banks, 96 lines by default). It merges them with software-raised requests, masks them per bank and splits them into two classes, normal and fast. For each class it picks one winning line and drives one output toward the processor. Software reaches the block through a simple word-wide register port with a 4 KB window. The write strobe, the byte address and the write data are sampled on the clock edge. Read data is combinational from the address.

Each line has its own priority and class route. When a class output is armed and any unmasked line of that class is pending, the output rises and the winning line number is latched into that class's code register. The output then stays high until software writes the matching re-arm bit. That write drops the output for one cycle and arms it again. A global mask can hold both outputs low. A soft reset returns the whole block to its power-up state.

Top module: `lvl_intc`

## Requirements
- R1: After reset both outputs are low and every bank mask reads all ones. The revision register (0x000) reads 0x21, the status register (0x014) reads 1, and both code registers (IRQ 0x040, FIQ 0x044) read 0.
- R2: Writes to read-only registers (revision, status, codes, raw input, pending) are ignored. A per-bank access whose bank field (address bits 6:5 in the 0x080 to 0x0FF window) is at or beyond the bank count reads 0 and changes nothing.
- R3: Bank b's registers sit at 0x080 + 0x20*b: raw +0x0, mask +0x4, mask-clear +0x8, mask-set +0xC, software-set +0x10, software-clear +0x14, pending-IRQ +0x18, pending-FIQ +0x1C. A mask write replaces the mask, mask-clear clears the written ones, and mask-set sets them. Mask-clear, mask-set and software-clear read 0.
- R4: A rising input sets its pending bit, and raw reads show the sampled inputs. Pending-IRQ reads pending AND NOT mask AND NOT route. Pending-FIQ reads pending AND NOT mask AND route.
- R5: When any input of a bank falls, that bank's pending vector becomes its current inputs OR its software vector.
- R6: Software-set ORs the written value into the software vector and into pending; it reads back the software vector. Software-clear removes the written bits from the software vector and then sets pending to the software vector AND the current inputs.
- R7: The winner of a class is the eligible line with the smallest priority value. Among lines with equal priority, the highest line number wins.
- R8: An armed output with any eligible line and the global mask off rises one cycle later, latches the winner into its code register and disarms. It stays high until re-armed or reset. Reading the code registers has no side effect.
- R9: In a control write (0x048), bit 0 re-arms IRQ and bit 1 re-arms FIQ. The chosen output is low in the following cycle and rises again one cycle after that if an eligible line remains.
- R10: Control bit 2 is a global mask: while it is set neither output rises. It reads back in bit 2 of the control register.
- R11: Line n is configured at 0x100 + 4*n: priority in bits 7:2 (6 bits) and route in bit 0 (1 = FIQ class). It reads back in the same positions with bit 1 zero.
- R12: Sysconfig (0x010) bit 0 stores autoidle and reads back in bit 0. Writing sysconfig bit 1 performs a soft reset to the R1 state. The idle register (0x050) keeps 2 bits and protection (0x04C) keeps bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | NUM_BANKS*32 | Level interrupt request lines |
| wrEn | input | 1 | Register write strobe |
| addr | input | 12 | Byte address of the register access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| irqOut | output | 1 | Normal-class interrupt output |
| fiqOut | output | 1 | Fast-class interrupt output |

## Verification
The bench targets four corner cases:
- A priority tie between two lines. A resolver that keeps the first match instead of the last reports the lower line number.
- Software-clear issued while a hardware line is still high. This must wipe pending down to software AND inputs, and a later falling edge elsewhere must bring the removed software bit back. A design that only masks the cleared bits, or that ignores falls, leaves pending-IRQ reads wrong.
- Re-arm writes issued under the global mask. An output that rises under the mask, or that does not drop for the re-arm cycle, breaks the per-cycle output comparison.
- Accesses to the absent fourth bank and writes to read-only registers. A missing bank check aliases another bank's mask.

// File: rtl/lvl_intc_pkg.sv
package lvl_intc_pkg;

  localparam int BANK_BITS = 32;

  typedef enum logic [3:0] {
    RK_NONE, RK_REV, RK_SYSCFG, RK_STAT, RK_CODE_IRQ, RK_CODE_FIQ,
    RK_CTRL, RK_PROT, RK_IDLE, RK_RAW, RK_MASK, RK_SWSET,
    RK_PEND_IRQ, RK_PEND_FIQ, RK_LINE
  } readKind_e;

  typedef struct packed {
    logic maskWr;
    logic maskClr;
    logic maskSet;
    logic swSet;
    logic swClr;
    logic lineWr;
    logic ctrlWr;
    logic sysWr;
    logic protWr;
    logic idleWr;
  } strobes_t;

endpackage

// File: rtl/lvl_intc_resolver.sv
module lvl_intc_resolver #(
  parameter int NUM_LINES = 96,
  parameter int PRIO_W    = 6,
  localparam int LINE_W   = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             reqVec,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prioVec,
  output logic                             anyReq,
  output logic [LINE_W-1:0]                winLine
);

  logic [PRIO_W-1:0] bestPrio;

  // Ascending scan with <= so a later (higher) line wins a tie.
  always_comb begin
    bestPrio = '1;
    winLine  = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (reqVec[i] && (prioVec[i] <= bestPrio)) begin
        bestPrio = prioVec[i];
        winLine  = LINE_W'(i);
      end
    end
  end

  assign anyReq = |reqVec;

endmodule

// File: rtl/lvl_intc_ctrl.sv
module lvl_intc_ctrl
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 12,
  localparam int NUM_LINES = NUM_BANKS * BANK_BITS,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output strobes_t          wrStb,
  output readKind_e         rdKind,
  output logic [BANK_W-1:0] bankIdx,
  output logic [LINE_W-1:0] lineIdx
);

  localparam logic [ADDR_W-1:0] LINE_BASE  = ADDR_W'(256);
  localparam logic [ADDR_W-1:0] LINE_LIMIT = ADDR_W'(256 + 4 * NUM_LINES);

  logic [ADDR_W-1:0] lineOff;
  logic [1:0]        bankRaw;
  logic              inLineWin, inBankWin, inGlobalWin, bankOk;

  assign lineOff     = addr - LINE_BASE;
  assign lineIdx     = lineOff[LINE_W+1:2];
  assign bankRaw     = addr[6:5];
  assign bankIdx     = BANK_W'(bankRaw);
  assign inLineWin   = (addr >= LINE_BASE) && (addr < LINE_LIMIT);
  assign inBankWin   = (addr[ADDR_W-1:7] == (ADDR_W-7)'(1));
  assign inGlobalWin = (addr[ADDR_W-1:7] == '0);
  assign bankOk      = ({30'd0, bankRaw} < NUM_BANKS);

  always_comb begin
    wrStb  = '0;
    rdKind = RK_NONE;
    if (inLineWin) begin
      rdKind       = RK_LINE;
      wrStb.lineWr = wrEn;
    end else if (inBankWin && bankOk) begin
      case (addr[4:2])
        3'd0: rdKind = RK_RAW;
        3'd1: begin rdKind = RK_MASK; wrStb.maskWr = wrEn; end
        3'd2: wrStb.maskClr = wrEn;
        3'd3: wrStb.maskSet = wrEn;
        3'd4: begin rdKind = RK_SWSET; wrStb.swSet = wrEn; end
        3'd5: wrStb.swClr = wrEn;
        3'd6: rdKind = RK_PEND_IRQ;
        default: rdKind = RK_PEND_FIQ;
      endcase
    end else if (inGlobalWin) begin
      case (addr[6:2])
        5'h00: rdKind = RK_REV;
        5'h04: begin rdKind = RK_SYSCFG; wrStb.sysWr = wrEn; end
        5'h05: rdKind = RK_STAT;
        5'h10: rdKind = RK_CODE_IRQ;
        5'h11: rdKind = RK_CODE_FIQ;
        5'h12: begin rdKind = RK_CTRL; wrStb.ctrlWr = wrEn; end
        5'h13: begin rdKind = RK_PROT; wrStb.protWr = wrEn; end
        5'h14: begin rdKind = RK_IDLE; wrStb.idleWr = wrEn; end
        default: rdKind = RK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lvl_intc_datapath.sv
module lvl_intc_datapath
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS     = 3,
  parameter int PRIO_W        = 6,
  parameter logic [7:0] REVISION = 8'h21,
  localparam int NUM_LINES = NUM_BANKS * BANK_BITS,
  localparam int LINE_W    = $clog2(NUM_LINES),
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  strobes_t             wrStb,
  input  readKind_e            rdKind,
  input  logic [BANK_W-1:0]    bankIdx,
  input  logic [LINE_W-1:0]    lineIdx,
  input  logic [31:0]          wrData,
  output logic [31:0]          rdData,
  output logic                 irqOut,
  output logic                 fiqOut
);

  logic [NUM_BANKS-1:0][BANK_BITS-1:0] rawQ, pendQ, maskQ, swQ;
  logic [NUM_BANKS-1:0][BANK_BITS-1:0] pendNx, maskNx, swNx;
  logic [NUM_LINES-1:0][PRIO_W-1:0]    prioQ;
  logic [NUM_LINES-1:0]                routeQ;
  logic [NUM_LINES-1:0]                activeVec;
  logic [1:0]                          outQ, armedQ, rearm;
  logic [LINE_W-1:0]                   codeQ [2];
  logic [LINE_W-1:0]                   winLine [2];
  logic                                anyReq [2];
  logic                                globalMask, autoIdle, protQ;
  logic [1:0]                          idleQ;
  logic                                softRst;

  assign softRst = wrStb.sysWr & wrData[1];
  assign rearm   = {2{wrStb.ctrlWr}} & wrData[1:0];

  // Per-bank pending, software and mask next state
  always_comb begin
    logic [BANK_BITS-1:0] inB, riseB, fallB;
    logic                 selB;
    for (int b = 0; b < NUM_BANKS; b++) begin
      inB   = lineIn[b*BANK_BITS +: BANK_BITS];
      riseB = inB & ~rawQ[b];
      fallB = ~inB & rawQ[b];
      selB  = (bankIdx == BANK_W'(b));
      pendNx[b] = pendQ[b];
      swNx[b]   = swQ[b];
      maskNx[b] = maskQ[b];
      if (|fallB) pendNx[b] = inB | swQ[b];
      pendNx[b] = pendNx[b] | riseB;
      if (selB && wrStb.swSet) begin
        swNx[b]   = swQ[b] | wrData;
        pendNx[b] = pendNx[b] | swNx[b];
      end
      if (selB && wrStb.swClr) begin
        swNx[b]   = swQ[b] & ~wrData;
        pendNx[b] = swNx[b] & inB;
      end
      if (selB && wrStb.maskWr)  maskNx[b] = wrData;
      if (selB && wrStb.maskClr) maskNx[b] = maskQ[b] & ~wrData;
      if (selB && wrStb.maskSet) maskNx[b] = maskQ[b] | wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawQ <= '0; pendQ <= '0; swQ <= '0; maskQ <= '1;
    end else if (softRst) begin
      rawQ <= '0; pendQ <= '0; swQ <= '0; maskQ <= '1;
    end else begin
      rawQ  <= lineIn;
      pendQ <= pendNx;
      swQ   <= swNx;
      maskQ <= maskNx;
    end
  end

  // Line configuration and global control
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioQ <= '0; routeQ <= '0; globalMask <= 1'b0;
      autoIdle <= 1'b0; protQ <= 1'b0; idleQ <= '0;
    end else if (softRst) begin
      prioQ <= '0; routeQ <= '0; globalMask <= 1'b0;
      autoIdle <= 1'b0; protQ <= 1'b0; idleQ <= '0;
    end else begin
      if (wrStb.lineWr) begin
        prioQ[lineIdx]  <= wrData[PRIO_W+1:2];
        routeQ[lineIdx] <= wrData[0];
      end
      if (wrStb.ctrlWr) globalMask <= wrData[2];
      if (wrStb.sysWr)  autoIdle   <= wrData[0];
      if (wrStb.protWr) protQ      <= wrData[0];
      if (wrStb.idleWr) idleQ      <= wrData[1:0];
    end
  end

  assign activeVec = pendQ & ~maskQ;

  // One resolver per class: 0 = IRQ, 1 = FIQ
  for (genvar c = 0; c < 2; c++) begin : g_cls
    logic [NUM_LINES-1:0] reqVec;
    assign reqVec = (c == 1) ? (activeVec & routeQ) : (activeVec & ~routeQ);
    lvl_intc_resolver #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_res (
      .reqVec  (reqVec),
      .prioVec (prioQ),
      .anyReq  (anyReq[c]),
      .winLine (winLine[c])
    );
  end

  // Output arming
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ <= '0; armedQ <= '1; codeQ[0] <= '0; codeQ[1] <= '0;
    end else if (softRst) begin
      outQ <= '0; armedQ <= '1; codeQ[0] <= '0; codeQ[1] <= '0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (rearm[c]) begin
          outQ[c]   <= 1'b0;
          armedQ[c] <= 1'b1;
        end else if (armedQ[c] && anyReq[c] && !globalMask) begin
          outQ[c]   <= 1'b1;
          armedQ[c] <= 1'b0;
          codeQ[c]  <= winLine[c];
        end
      end
    end
  end

  assign irqOut = outQ[0];
  assign fiqOut = outQ[1];

  // Read mux
  always_comb begin
    rdData = '0;
    case (rdKind)
      RK_REV:      rdData = 32'(REVISION);
      RK_SYSCFG:   rdData = 32'(autoIdle);
      RK_STAT:     rdData = 32'd1;
      RK_CODE_IRQ: rdData = 32'(codeQ[0]);
      RK_CODE_FIQ: rdData = 32'(codeQ[1]);
      RK_CTRL:     rdData = {29'd0, globalMask, 2'b00};
      RK_PROT:     rdData = 32'(protQ);
      RK_IDLE:     rdData = 32'(idleQ);
      RK_RAW:      rdData = rawQ[bankIdx];
      RK_MASK:     rdData = maskQ[bankIdx];
      RK_SWSET:    rdData = swQ[bankIdx];
      RK_PEND_IRQ: rdData = pendQ[bankIdx] & ~maskQ[bankIdx]
                            & ~routeQ[bankIdx*BANK_BITS +: BANK_BITS];
      RK_PEND_FIQ: rdData = pendQ[bankIdx] & ~maskQ[bankIdx]
                            & routeQ[bankIdx*BANK_BITS +: BANK_BITS];
      RK_LINE:     rdData = 32'({prioQ[lineIdx], 1'b0, routeQ[lineIdx]});
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
  import lvl_intc_pkg::*;
#(
  parameter int NUM_BANKS        = 3,
  parameter int PRIO_W           = 6,
  parameter logic [7:0] REVISION = 8'h21
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_BANKS*BANK_BITS-1:0] lineIn,
  input  logic                           wrEn,
  input  logic [11:0]                    addr,
  input  logic [31:0]                    wrData,
  output logic [31:0]                    rdData,
  output logic                           irqOut,
  output logic                           fiqOut
);

  localparam int NUM_LINES = NUM_BANKS * BANK_BITS;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  strobes_t          wrStb;
  readKind_e         rdKind;
  logic [BANK_W-1:0] bankIdx;
  logic [LINE_W-1:0] lineIdx;

  lvl_intc_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(12)) u_ctrl (
    .wrEn    (wrEn),
    .addr    (addr),
    .wrStb   (wrStb),
    .rdKind  (rdKind),
    .bankIdx (bankIdx),
    .lineIdx (lineIdx)
  );

  lvl_intc_datapath #(.NUM_BANKS(NUM_BANKS), .PRIO_W(PRIO_W), .REVISION(REVISION)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .lineIn  (lineIn),
    .wrStb   (wrStb),
    .rdKind  (rdKind),
    .bankIdx (bankIdx),
    .lineIdx (lineIdx),
    .wrData  (wrData),
    .rdData  (rdData),
    .irqOut  (irqOut),
    .fiqOut  (fiqOut)
  );

endmodule

// File: rtl/lvl_intc_checker.sv
module lvl_intc_checker #(
  parameter logic [7:0] REVISION = 8'h21
) (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [11:0] addr,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        irqOut,
  input logic        fiqOut,
  input logic        globalMask
);

  logic ctrlWrite, sysWrite;
  assign ctrlWrite = wrEn && (addr == 12'h048);
  assign sysWrite  = wrEn && (addr == 12'h010);

  a_r1_status_read: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'h014) |-> (rdData == 32'd1));

  a_r1_revision_read: assert property (@(posedge clk) disable iff (!rstN)
    (addr == 12'h000) |-> (rdData == 32'(REVISION)));

  a_r3_alias_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    ((addr == 12'h088) || (addr == 12'h08C)) |-> (rdData == 32'd0));

  a_r9_irq_rearm_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && wrData[0]) |=> !irqOut);

  a_r9_fiq_rearm_drops: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && wrData[1]) |=> !fiqOut);

  a_r8_irq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(ctrlWrite && wrData[0]) && !(sysWrite && wrData[1])) |=> irqOut);

  a_r8_fiq_holds: assert property (@(posedge clk) disable iff (!rstN)
    (fiqOut && !(ctrlWrite && wrData[1]) && !(sysWrite && wrData[1])) |=> fiqOut);

  a_r10_no_rise_under_mask: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(irqOut) || $rose(fiqOut)) |-> !$past(globalMask));

  a_r12_softreset_clears: assert property (@(posedge clk) disable iff (!rstN)
    (sysWrite && wrData[1]) |=> (!irqOut && !fiqOut));

endmodule

bind lvl_intc lvl_intc_checker #(.REVISION(REVISION)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .irqOut     (irqOut),
  .fiqOut     (fiqOut),
  .globalMask (u_dp.globalMask)
);

// File: tb/lvl_intc_test.sv
module lvl_intc_test;

  localparam int NB = 3;
  localparam int NL = NB * 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic [NL-1:0] lineIn;
  logic          wrEn;
  logic [11:0]   addr;
  logic [31:0]   wrData;
  logic [31:0]   rdData;
  logic          irqOut, fiqOut;

  always #4 clk = ~clk;

  lvl_intc uut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  int checks = 0;
  int errors = 0;

  // Behavioural reference model
  logic [31:0] mRaw [NB];
  logic [31:0] mPend[NB];
  logic [31:0] mMask[NB];
  logic [31:0] mSw  [NB];
  int          mPrio[NL];
  bit          mRoute[NL];
  bit          mGm, mAuto, mProt;
  bit [1:0]    mIdle;
  bit          mArm[2];
  bit          mOut[2];
  int          mCode[2];

  task automatic mReset();
    for (int b = 0; b < NB; b++) begin
      mRaw[b] = '0; mPend[b] = '0; mMask[b] = '1; mSw[b] = '0;
    end
    for (int i = 0; i < NL; i++) begin
      mPrio[i] = 0; mRoute[i] = 1'b0;
    end
    mGm = 0; mAuto = 0; mProt = 0; mIdle = '0;
    for (int c = 0; c < 2; c++) begin
      mArm[c] = 1; mOut[c] = 0; mCode[c] = 0;
    end
  endtask

  function automatic int mWinner(int cls);
    int best = 1000;
    int w = -1;
    for (int i = 0; i < NL; i++) begin
      if (mPend[i/32][i%32] && !mMask[i/32][i%32] && (mRoute[i] == (cls == 1))
          && mPrio[i] <= best) begin
        best = mPrio[i];
        w = i;
      end
    end
    return w;
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a0);
    logic [11:0] a = {a0[11:2], 2'b00};
    logic [31:0] rt;
    int b;
    if (a >= 12'h100 && a < 12'h100 + 12'(4*NL)) begin
      int li = (int'(a) - 256) / 4;
      return 32'((mPrio[li] << 2) | int'(mRoute[li]));
    end
    if (a >= 12'h080 && a < 12'h100) begin
      b = int'(a[6:5]);
      if (b >= NB) return 0;
      for (int k = 0; k < 32; k++) rt[k] = mRoute[b*32+k];
      case (a[4:2])
        3'd0: return mRaw[b];
        3'd1: return mMask[b];
        3'd4: return mSw[b];
        3'd6: return mPend[b] & ~mMask[b] & ~rt;
        3'd7: return mPend[b] & ~mMask[b] & rt;
        default: return 0;
      endcase
    end
    case (a)
      12'h000: return 32'h21;
      12'h010: return 32'(mAuto);
      12'h014: return 1;
      12'h040: return 32'(mCode[0]);
      12'h044: return 32'(mCode[1]);
      12'h048: return {29'd0, mGm, 2'b00};
      12'h04C: return 32'(mProt);
      12'h050: return 32'(mIdle);
      default: return 0;
    endcase
  endfunction

  task automatic mStep();
    logic [11:0] a = {addr[11:2], 2'b00};
    logic [31:0] d = wrData;
    bit w = wrEn;
    int win[2];
    for (int c = 0; c < 2; c++) win[c] = mWinner(c);
    for (int c = 0; c < 2; c++) begin
      if (w && a == 12'h048 && d[c]) begin
        mOut[c] = 0; mArm[c] = 1;
      end else if (mArm[c] && win[c] >= 0 && !mGm) begin
        mOut[c] = 1; mArm[c] = 0; mCode[c] = win[c];
      end
    end
    for (int b = 0; b < NB; b++) begin
      logic [31:0] inB = lineIn[b*32 +: 32];
      logic [31:0] rise = inB & ~mRaw[b];
      logic [31:0] fall = ~inB & mRaw[b];
      bit sel = w && a >= 12'h080 && a < 12'h100 && int'(a[6:5]) == b;
      if (fall != 0) mPend[b] = inB | mSw[b];
      mPend[b] |= rise;
      if (sel) begin
        case (a[4:2])
          3'd1: mMask[b] = d;
          3'd2: mMask[b] &= ~d;
          3'd3: mMask[b] |= d;
          3'd4: begin mSw[b] |= d; mPend[b] |= mSw[b]; end
          3'd5: begin mSw[b] &= ~d; mPend[b] = mSw[b] & inB; end
          default: ;
        endcase
      end
      mRaw[b] = inB;
    end
    if (w && a >= 12'h100 && a < 12'h100 + 12'(4*NL)) begin
      int li = (int'(a) - 256) / 4;
      mPrio[li] = int'(d[7:2]); mRoute[li] = d[0];
    end
    if (w && a == 12'h048) mGm = d[2];
    if (w && a == 12'h04C) mProt = d[0];
    if (w && a == 12'h050) mIdle = d[1:0];
    if (w && a == 12'h010) begin
      mAuto = d[0];
      if (d[1]) mReset();
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) mReset();
    else mStep();
  end

  task automatic cmp(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the clock edge
  always @(negedge clk) begin
    if (rstN) begin
      #2;
      cmp(32'(irqOut), 32'(mOut[0]), "R8 irqOut vs model");
      cmp(32'(fiqOut), 32'(mOut[1]), "R8 fiqOut vs model");
      cmp(rdData, mRead(addr), "R2 rdData vs model");
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic chk(logic [11:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = a;
    #1 cmp(rdData, exp, tag);
  endtask

  task automatic outChk(bit irqExp, bit fiqExp, string tag);
    @(negedge clk);
    #1;
    cmp(32'(irqOut), 32'(irqExp), tag);
    cmp(32'(fiqOut), 32'(fiqExp), tag);
  endtask

  task automatic setLine(int idx, bit v);
    @(negedge clk);
    lineIn[idx] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN = 1'b0; lineIn = '0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    outChk(0, 0, "R1 outputs low");
    chk(12'h000, 32'h21, "R1 revision");
    chk(12'h014, 32'd1, "R1 status");
    chk(12'h084, 32'hFFFF_FFFF, "R1 mask bank0");
    chk(12'h0C4, 32'hFFFF_FFFF, "R1 mask bank2");
    chk(12'h040, 32'd0, "R1 irq code");

    // R11 line configuration
    wr(12'h114, 32'h28);
    chk(12'h114, 32'h28, "R11 line5 prio 10");
    wr(12'h11C, 32'hFFFF_FFFF);
    chk(12'h11C, 32'hFD, "R11 line7 prio 63 route fiq");

    // R3 mask aliases
    wr(12'h088, 32'hF0);
    chk(12'h084, 32'hFFFF_FF0F, "R3 mask-clear");
    chk(12'h088, 32'd0, "R3 mask-clear reads 0");
    wr(12'h08C, 32'h10);
    chk(12'h084, 32'hFFFF_FF1F, "R3 mask-set");
    chk(12'h08C, 32'd0, "R3 mask-set reads 0");

    // R4 / R8 first assertion
    setLine(5, 1);
    idle(3);
    outChk(1, 0, "R8 irq rises");
    chk(12'h098, 32'h20, "R4 pending irq");
    chk(12'h040, 32'd5, "R8 code line5");
    chk(12'h040, 32'd5, "R8 code read twice");
    outChk(1, 0, "R8 code read no side effect");

    // R7 tie and priority
    setLine(6, 1);
    setLine(4, 1);
    wr(12'h088, 32'h10);
    idle(2);
    chk(12'h040, 32'd5, "R8 code held until rearm");
    wr(12'h048, 32'h1);
    outChk(0, 0, "R9 irq drops on rearm");
    idle(2);
    outChk(1, 0, "R9 irq rises again");
    chk(12'h040, 32'd6, "R7 tie goes to higher line");
    setLine(6, 0);
    idle(2);
    wr(12'h048, 32'h1);
    idle(3);
    chk(12'h040, 32'd4, "R7 lower priority value wins");

    // FIQ class
    setLine(7, 1);
    idle(3);
    outChk(1, 1, "R8 fiq rises");
    chk(12'h044, 32'd7, "R8 fiq code");
    chk(12'h09C, 32'h80, "R4 pending fiq");
    chk(12'h098, 32'h30, "R4 pending irq excludes fiq");

    // R10 global mask
    wr(12'h048, 32'h7);
    idle(3);
    outChk(0, 0, "R10 global mask blocks");
    chk(12'h048, 32'h4, "R10 mask reads back");
    wr(12'h048, 32'h0);
    idle(2);
    outChk(1, 1, "R10 release reasserts");

    // R6 / R5 software vector and falling edge
    wr(12'h0B0, 32'h3);
    chk(12'h0B0, 32'h3, "R6 sw vector");
    chk(12'h0B8, 32'h0, "R6 masked sw pending");
    wr(12'h0A8, 32'h3);
    chk(12'h0B8, 32'h3, "R6 sw pending unmasked");
    setLine(36, 1);
    idle(2);
    wr(12'h0B4, 32'h1);
    chk(12'h0B8, 32'h0, "R6 sw clear gives sw AND raw");
    chk(12'h0B0, 32'h2, "R6 sw vector after clear");
    setLine(37, 1);
    wr(12'h0A8, 32'h20);
    chk(12'h0B8, 32'h20, "R4 rise bank1");
    chk(12'h0A0, 32'h30, "R4 raw bank1");
    setLine(36, 0);
    idle(2);
    chk(12'h0B8, 32'h22, "R5 fall gives raw OR sw");

    // R2 rejected bank and read-only writes
    chk(12'h0E4, 32'd0, "R2 bank3 reads 0");
    wr(12'h0E4, 32'd0);
    chk(12'h084, 32'hFFFF_FF0F, "R2 bank3 write no alias");
    wr(12'h000, 32'd0);
    chk(12'h000, 32'h21, "R2 revision read-only");
    wr(12'h040, 32'h55);
    chk(12'h040, 32'd4, "R2 code read-only");
    wr(12'h098, 32'hFFFF_FFFF);
    chk(12'h098, 32'h30, "R2 pending read-only");

    // R12 sysconfig, idle, protection, soft reset
    wr(12'h010, 32'h1);
    chk(12'h010, 32'h1, "R12 autoidle");
    wr(12'h050, 32'hFF);
    chk(12'h050, 32'h3, "R12 idle 2 bits");
    wr(12'h04C, 32'h1);
    chk(12'h04C, 32'h1, "R12 protection bit");
    wr(12'h010, 32'h2);
    outChk(0, 0, "R12 soft reset outputs");
    chk(12'h084, 32'hFFFF_FFFF, "R12 soft reset mask");
    chk(12'h114, 32'd0, "R12 soft reset line cfg");
    chk(12'h010, 32'd0, "R12 soft reset sysconfig");
    chk(12'h050, 32'd0, "R12 soft reset idle");
    idle(4);
    outChk(0, 0, "R12 masked after soft reset");

    finishRun();
  end

endmodule